// File: doc/BRIEF.md
# Pixel Acquisition Sequencer

This block runs one acquisition cycle of a photon-counting pixel array. It waits idle with every cell armed until a master trigger arrives. It then holds off for a programmable number of cycles and samples a validation input. A low validation means the trigger came from a dark count, and the block aborts straight into a short reset phase. A high validation starts a programmable collection window. After that window the block walks the array one row per cycle and adds each row's photon count into an accumulator.

While a row is read, the row read in the previous cycle is recharged. This spreads the recharge current over the readout instead of dumping it all at the global reset. After the last row is read, one more cycle recharges that final row. The block then issues a one-cycle done strobe with the total. Last, a fixed-length reset phase drives the global recharge and the time-to-digital converter reset, and the block returns to idle.

The durations are cycle counts taken from inputs. Each count is loaded into a shared down-counter when its state is entered.

Top module: `acq_seq_ctrl`

## Requirements
- R1: After reset the block is idle: row_rd_o, rchg_en_o, done_o, glob_rchg_o and tdc_rst_o are 0, row_sel_o and rchg_row_o are 0, and count_o is 0.
- R2: A high trig_i in idle starts the hold-off phase. The phase lasts max(hold_cycles_i, 1) cycles, and during it every control output stays low.
- R3: valid_i is sampled only in the last hold-off cycle. If it is 0 there, the reset phase follows at once, no row is read, and count_o keeps its previous value.
- R4: If valid_i is 1 in the last hold-off cycle, the collection phase follows and lasts max(collect_cycles_i, 1) cycles with all control outputs low.
- R5: Readout then lasts ROWS cycles. In readout cycle k, row_rd_o is 1 and row_sel_o is k. row_cnt_i in that cycle is added to the total. Whenever row_rd_o is 0, row_sel_o is 0.
- R6: In readout cycle k ≥ 1, rchg_en_o is 1 and rchg_row_o is k-1. In cycle 0, rchg_en_o is 0. In the single cycle after the last row, rchg_en_o is 1, rchg_row_o is ROWS-1 and row_rd_o is 0. Whenever rchg_en_o is 0, rchg_row_o is 0.
- R7: done_o is 1 only in the cycle after the last row, and for exactly one cycle. In that cycle count_o is the sum of all ROWS row counts. The total is cleared when readout starts, and count_o holds it until the next readout.
- R8: The reset phase lasts RST_CYC cycles with glob_rchg_o and tdc_rst_o both 1 and no row activity. The block is then idle again.
- R9: trig_i is ignored in every state except idle. A trigger held high through a whole event does not lengthen or restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Master trigger |
| valid_i | input | 1 | Event validation level |
| hold_cycles_i | input | TMR_W | Hold-off length in cycles |
| collect_cycles_i | input | TMR_W | Collection length in cycles |
| row_cnt_i | input | CNT_W | Photon count of the selected row |
| row_sel_o | output | ROW_W | Row being read |
| row_rd_o | output | 1 | Row read enable |
| rchg_row_o | output | ROW_W | Row being recharged |
| rchg_en_o | output | 1 | Row recharge enable |
| glob_rchg_o | output | 1 | Global pixel recharge |
| tdc_rst_o | output | 1 | Time-to-digital converter reset |
| count_o | output | ACC_W | Accumulated photon count |
| done_o | output | 1 | One-cycle strobe with the final count |

## Verification
A wrong state or a miscounted timer shows at the ports within one cycle, as a readout or reset that starts early or late relative to the trigger. For that reason the bench compares every control output in every cycle of every event against a schedule it computes itself. A row walker that is off by one shows up as a wrong row_sel_o or rchg_row_o on the first readout cycle. An accumulator that was not cleared or was mis-added gives a wrong count_o at the done strobe. A trigger held high during an event would, if not ignored, show a second hold-off without returning to idle. The sweep therefore repeats each timing setting with the trigger held high all through the event.

// File: rtl/acq_seq_pkg.sv
package acq_seq_pkg;
  typedef enum logic [2:0] {
    ST_READY    = 3'd0,
    ST_VALIDATE = 3'd1,
    ST_COLLECT  = 3'd2,
    ST_READOUT  = 3'd3,
    ST_RESET    = 3'd4
  } acq_state_e;
endpackage

// File: rtl/acq_timer.sv
module acq_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         run_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  assign expire_o = (cnt_q <= W'(1));
  assign cnt_en   = load_i || (run_i && !expire_o);

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)
      cnt_d = load_val_i;
    else if (run_i && !expire_o)
      cnt_d = cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (cnt_en)
      cnt_q <= cnt_d;
  end

  // R2
  timer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (cnt_q == $past(load_val_i)));

  // R4
  timer_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !load_i && !expire_o) |=> (cnt_q == $past(cnt_q) - W'(1)));
endmodule

// File: rtl/acq_row_walker.sv
module acq_row_walker #(
  parameter int ROWS  = 32,
  parameter int ROW_W = 5,
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             walk_i,
  output logic [ROW_W-1:0] row_sel_o,
  output logic             row_rd_o,
  output logic [ROW_W-1:0] rchg_row_o,
  output logic             rchg_en_o,
  output logic             last_o
);
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             idx_en;

  assign last_o     = walk_i && (idx_q == IDX_W'(ROWS));
  assign row_rd_o   = walk_i && (idx_q < IDX_W'(ROWS));
  assign rchg_en_o  = walk_i && (idx_q != '0);
  assign row_sel_o  = row_rd_o  ? ROW_W'(idx_q) : '0;
  assign rchg_row_o = rchg_en_o ? ROW_W'(idx_q - IDX_W'(1)) : '0;

  assign idx_en = walk_i || (idx_q != '0);

  always_comb begin
    idx_d = '0;
    if (walk_i && !last_o)
      idx_d = idx_q + IDX_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      idx_q <= '0;
    else if (idx_en)
      idx_q <= idx_d;
  end

  // R6
  rchg_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rd_o && walk_i) |=> (rchg_en_o && rchg_row_o == $past(row_sel_o)));

  // R5
  row_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (row_rd_o && $past(row_rd_o) && $past(walk_i) && walk_i)
      |-> (row_sel_o == $past(row_sel_o) + ROW_W'(1)));

  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= IDX_W'(ROWS));
endmodule

// File: rtl/acq_accum.sv
module acq_accum #(
  parameter int CNT_W = 8,
  parameter int ACC_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [CNT_W-1:0] val_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             acc_en;

  assign acc_en = clr_i || add_i;
  assign acc_o  = acc_q;

  always_comb begin
    acc_d = acc_q;
    if (clr_i)
      acc_d = '0;
    else if (add_i)
      acc_d = acc_q + ACC_W'(val_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_q <= '0;
    else if (acc_en)
      acc_q <= acc_d;
  end

  // R7
  acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (acc_q == '0));

  // R5
  acc_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !clr_i) |=> (acc_q == $past(acc_q) + ACC_W'($past(val_i))));

  // R7
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!add_i && !clr_i) |=> $stable(acc_q));
endmodule

// File: rtl/acq_seq_ctrl.sv
module acq_seq_ctrl
  import acq_seq_pkg::*;
#(
  parameter int ROWS    = 32,
  parameter int CNT_W   = 8,
  parameter int TMR_W   = 10,
  parameter int RST_CYC = 2,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int IDX_W  = $clog2(ROWS + 1),
  localparam int ACC_W  = CNT_W + $clog2(ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig_i,
  input  logic             valid_i,
  input  logic [TMR_W-1:0] hold_cycles_i,
  input  logic [TMR_W-1:0] collect_cycles_i,
  input  logic [CNT_W-1:0] row_cnt_i,
  output logic [ROW_W-1:0] row_sel_o,
  output logic             row_rd_o,
  output logic [ROW_W-1:0] rchg_row_o,
  output logic             rchg_en_o,
  output logic             glob_rchg_o,
  output logic             tdc_rst_o,
  output logic [ACC_W-1:0] count_o,
  output logic             done_o
);
  localparam logic [TMR_W-1:0] RST_LEN = TMR_W'(RST_CYC);

  acq_state_e       state_q, state_d;
  logic             tmr_load, tmr_run, tmr_expire;
  logic [TMR_W-1:0] tmr_val;
  logic             walk, walk_last, acc_clr;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = hold_cycles_i;
    acc_clr  = 1'b0;
    unique case (state_q)
      ST_READY: begin
        if (trig_i) begin
          state_d  = ST_VALIDATE;
          tmr_load = 1'b1;
          tmr_val  = hold_cycles_i;
        end
      end
      ST_VALIDATE: begin
        if (tmr_expire) begin
          tmr_load = 1'b1;
          if (valid_i) begin
            state_d = ST_COLLECT;
            tmr_val = collect_cycles_i;
          end else begin
            state_d = ST_RESET;
            tmr_val = RST_LEN;
          end
        end
      end
      ST_COLLECT: begin
        if (tmr_expire) begin
          state_d = ST_READOUT;
          acc_clr = 1'b1;
        end
      end
      ST_READOUT: begin
        if (walk_last) begin
          state_d  = ST_RESET;
          tmr_load = 1'b1;
          tmr_val  = RST_LEN;
        end
      end
      ST_RESET: begin
        if (tmr_expire)
          state_d = ST_READY;
      end
      default: state_d = ST_READY;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_READY;
    else
      state_q <= state_d;
  end

  assign tmr_run = (state_q == ST_VALIDATE) || (state_q == ST_COLLECT) ||
                   (state_q == ST_RESET);
  assign walk    = (state_q == ST_READOUT);

  acq_timer #(.W(TMR_W)) tmr_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .run_i      (tmr_run),
    .expire_o   (tmr_expire)
  );

  acq_row_walker #(.ROWS(ROWS), .ROW_W(ROW_W), .IDX_W(IDX_W)) walk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .walk_i     (walk),
    .row_sel_o  (row_sel_o),
    .row_rd_o   (row_rd_o),
    .rchg_row_o (rchg_row_o),
    .rchg_en_o  (rchg_en_o),
    .last_o     (walk_last)
  );

  acq_accum #(.CNT_W(CNT_W), .ACC_W(ACC_W)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (acc_clr),
    .add_i (row_rd_o),
    .val_i (row_cnt_i),
    .acc_o (count_o)
  );

  assign glob_rchg_o = (state_q == ST_RESET);
  assign tdc_rst_o   = (state_q == ST_RESET);
  assign done_o      = walk_last;

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R8
  reset_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (glob_rchg_o && tdc_rst_o));

  // R8
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    glob_rchg_o |-> (!row_rd_o && !rchg_en_o));

  // R9
  no_retrigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_READY && state_q != ST_VALIDATE) |=> (state_q != ST_VALIDATE));

  // R3
  dark_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_VALIDATE && tmr_expire && !valid_i) |=> (state_q == ST_RESET));
endmodule

// File: tb/acq_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module acq_seq_ctrl_tb_top;
  localparam int ROWS = 4;
  localparam int CNT_W = 4;
  localparam int TMR_W = 4;
  localparam int RST_CYC = 2;
  localparam int ROW_W = 2;
  localparam int ACC_W = CNT_W + $clog2(ROWS + 1);

  logic clk, rst_n, trig, valid;
  logic [TMR_W-1:0] hold_c, coll_c;
  logic [CNT_W-1:0] row_cnt;
  logic [ROW_W-1:0] row_sel, rchg_row;
  logic row_rd, rchg_en, glob_rchg, tdc_rst, done;
  logic [ACC_W-1:0] count;
  int seed;
  int checks, fails;

  acq_seq_ctrl #(.ROWS(ROWS), .CNT_W(CNT_W), .TMR_W(TMR_W), .RST_CYC(RST_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .trig_i(trig), .valid_i(valid),
    .hold_cycles_i(hold_c), .collect_cycles_i(coll_c), .row_cnt_i(row_cnt),
    .row_sel_o(row_sel), .row_rd_o(row_rd), .rchg_row_o(rchg_row),
    .rchg_en_o(rchg_en), .glob_rchg_o(glob_rchg), .tdc_rst_o(tdc_rst),
    .count_o(count), .done_o(done)
  );

  function automatic int pat(input int r, input int s);
    return (r * 5 + s * 7 + 3) % 16;
  endfunction

  assign row_cnt = CNT_W'(pat(int'(row_sel), seed));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  int prev_sum;

  task automatic run_event(input int h, input int c, input bit v, input bit spam, input int s);
    int hp, cp, t0, tail, last, sum, ctl, ectl, ersel, erch;
    hp = (h < 1) ? 1 : h;
    cp = (c < 1) ? 1 : c;
    t0 = hp + cp;
    tail = t0 + ROWS + 1;
    last = v ? (tail + RST_CYC) : (hp + RST_CYC);
    sum = 0;
    for (int r = 0; r < ROWS; r++) sum += pat(r, s);
    @(negedge clk);
    hold_c = TMR_W'(h); coll_c = TMR_W'(c); seed = s;
    trig = 1'b1; valid = !v;
    for (int k = 1; k <= last + 2; k++) begin
      bit rd, en, dn, rs;
      @(negedge clk);
      rd = 0; en = 0; dn = 0; rs = 0; ersel = 0; erch = 0;
      if (v) begin
        if (k > t0 && k <= t0 + ROWS) begin
          rd = 1; ersel = k - t0 - 1;
          if (ersel > 0) begin en = 1; erch = ersel - 1; end
        end
        if (k == tail) begin en = 1; erch = ROWS - 1; dn = 1; end
        if (k > tail && k <= last) rs = 1;
      end else begin
        if (k > hp && k <= last) rs = 1;
      end
      ectl = {rd, en, dn, rs, rs};
      ctl  = {row_rd, rchg_en, done, glob_rchg, tdc_rst};
      if (k <= hp)
        chk(ctl == ectl, "R2 holdoff controls", ctl, ectl);
      else if (!v)
        chk(ctl == ectl, (k > last) ? "R9 idle after dark" : "R3 dark abort to reset", ctl, ectl);
      else if (k <= t0)
        chk(ctl == ectl, "R4 collect controls", ctl, ectl);
      else if (k <= t0 + ROWS)
        chk(ctl == ectl, "R5 readout controls", ctl, ectl);
      else if (k == tail)
        chk(ctl == ectl, "R7 done cycle controls", ctl, ectl);
      else
        chk(ctl == ectl, (k > last) ? "R9 idle after event" : "R8 reset phase", ctl, ectl);
      chk(int'(row_sel) == ersel, "R5 row_sel", int'(row_sel), ersel);
      chk(int'(rchg_row) == erch, "R6 rchg_row", int'(rchg_row), erch);
      if (!v || k <= t0)
        chk(int'(count) == prev_sum, v ? "R7 count held before readout" : "R3 count kept on dark",
            int'(count), prev_sum);
      else if (k >= tail)
        chk(int'(count) == sum, "R7 final count", int'(count), sum);
      trig  = (k < last) ? spam : 1'b0;
      valid = (k == hp) ? v : !v;
    end
    if (v) prev_sum = sum;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    summary();
    $finish;
  end

  initial begin
    checks = 0; fails = 0; prev_sum = 0; seed = 0;
    rst_n = 1'b0; trig = 1'b0; valid = 1'b0; hold_c = '0; coll_c = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk({row_rd, rchg_en, done, glob_rchg, tdc_rst} == 5'b0, "R1 reset controls",
        int'({row_rd, rchg_en, done, glob_rchg, tdc_rst}), 0);
    chk(count == '0 && row_sel == '0 && rchg_row == '0, "R1 reset count/rows", int'(count), 0);
    for (int sp = 0; sp < 2; sp++)
      for (int h = 0; h < 5; h++)
        for (int c = 0; c < 4; c++)
          for (int v = 0; v < 2; v++)
            run_event(h, c, v[0], sp[0], h + c + sp);
    summary();
    $finish;
  end
endmodule